// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port Controller

This block is the register file and pad control for a single 16-pin general-purpose port. Software reaches it over a simple word-addressed register bus. Each pin has its own bit in each of these controls: analog select, direction, output latch, open-drain, pull-up enable, pull-down enable and change-notice enable. The block drives the pad-side output enable, output value, open-drain and pull controls from those bits. It also samples the pad inputs through a two-flop synchronizer into a readable input register.

Every control register occupies a slot of four words. The first word is a direct write. The other three are write-1 aliases that clear, set or invert only the pins whose bits are 1. Firmware can therefore change one pin without a read-modify-write, and cannot race with another agent that is changing other pins.

Top module: `gpio_port16`

## Requirements
- R1: After reset, every analog-select bit and every direction bit reads 1. The output latch, open-drain, pull-up, pull-down and change-notice registers read 0.
- R2: Byte address bits [7:4] select the register slot: 0 analog, 1 direction, 2 port input, 3 latch, 4 open-drain, 5 pull-up, 6 pull-down, 7 change-notice. Bits [3:2] select the alias: 0 direct, 1 clear, 2 set, 3 invert.
- R3: A direct write loads data bits [15:0] into the addressed register. Each 1 bit written to the clear, set or invert alias clears, sets or toggles that pin only, and the other pins are unchanged.
- R4: A read of any alias of a slot returns the base register value in bits [15:0], and bits [31:16] read 0. Slots 8 to 15 read 0, and writes to them change no register.
- R5: A write to any alias of slot 2 acts on the output latch, with the same alias semantics.
- R6: A read of slot 2 returns the pad input delayed by two clock edges. Bits whose analog-select bit is 1 read 0.
- R7: The pad output enable for a pin is 1 only when its direction bit is 0, its analog bit is 0, and it is not an open-drain pin driving a latched 1.
- R8: For an open-drain pin that is digital and has its direction bit at 0, the pad output value is 0 and the output enable equals the inverse of the latch bit. For a push-pull pin, the pad output value equals the latch bit.
- R9: The pull-up pad control equals the pull-up register. The pull-down pad control is 1 only when pull-down is enabled and pull-up is not, so pull-up wins.
- R10: Read data is registered and valid one cycle after a read strobe. Writes take effect on the clock edge of the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address; bits [1:0] ignored |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 16 | Pad input levels |
| pad_oe | output | 16 | Pad output enable |
| pad_out | output | 16 | Pad output value |
| pad_od | output | 16 | Pad open-drain mode |
| pad_pu | output | 16 | Pad pull-up enable |
| pad_pd | output | 16 | Pad pull-down enable |
| pad_analog | output | 16 | Pad analog mode |

## Verification
A register bit held in the wrong state shows up at two places. It appears on the pad controls in the cycle after the write edge, and on the bus in the cycle after a read strobe. A wrong alias decode, such as clear acting as set or a spill onto neighbouring pins, is therefore visible within two cycles. The bench reads back the register and compares the pad pins with values computed from the requirements. Synchronizer depth errors show as input reads arriving one edge early or late after a pad change.

// File: rtl/gpio_port16_pkg.sv
package gpio_port16_pkg;
    localparam int PINS      = 16;
    localparam int BUS_W     = 32;
    localparam int ADDR_W    = 8;
    localparam int SLOT_W    = 4;
    localparam int NUM_CTRL  = 8;

    typedef enum logic [3:0] {
        SLOT_ANA  = 4'd0,
        SLOT_DIR  = 4'd1,
        SLOT_PIN  = 4'd2,
        SLOT_LAT  = 4'd3,
        SLOT_ODR  = 4'd4,
        SLOT_PUP  = 4'd5,
        SLOT_PDN  = 4'd6,
        SLOT_CHG  = 4'd7
    } slot_e;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_CLR  = 2'd1,
        OP_SET  = 2'd2,
        OP_INV  = 2'd3
    } alias_e;
endpackage

// File: rtl/gpio_bit_reg.sv
// Per-register storage with direct, clear, set and invert update.
// Assumes at most one update request per cycle; RST_VAL is the reset pattern.
module gpio_bit_reg #(
    parameter int           W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        upd,
    input  gpio_port16_pkg::alias_e     op,
    input  logic [W-1:0]                data,
    output logic [W-1:0]                q
);
    import gpio_port16_pkg::*;

    logic [W-1:0] nxt;

    // Compute the updated value for the requested alias
    always_comb begin
        unique case (op)
            OP_LOAD: nxt = data;
            OP_CLR:  nxt = q & ~data;
            OP_SET:  nxt = q | data;
            default: nxt = q ^ data;
        endcase
    end

    // Hold or load the register
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= RST_VAL;
        else if (upd) q <= nxt;
    end
endmodule

// File: rtl/gpio_in_sync.sv
// Two-flop synchronizer for asynchronous pad inputs.
// Assumes each pad bit is independent; no bus coherence is implied.
module gpio_in_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta;

    // Shift pad levels through two stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            dout <= '0;
        end else begin
            meta <= din;
            dout <= meta;
        end
    end
endmodule

// File: rtl/gpio_pad_ctrl.sv
// Combinational mapping from control registers to pad controls.
// Assumes registers are already synchronous; pull-up has priority over pull-down.
module gpio_pad_ctrl #(
    parameter int W = 16
) (
    input  logic [W-1:0] ana,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] lat,
    input  logic [W-1:0] odr,
    input  logic [W-1:0] pup,
    input  logic [W-1:0] pdn,
    output logic [W-1:0] oe,
    output logic [W-1:0] dout,
    output logic [W-1:0] od,
    output logic [W-1:0] pu,
    output logic [W-1:0] pd
);
    // Derive per-pin pad controls
    always_comb begin
        for (int i = 0; i < W; i++) begin
            if (odr[i]) begin
                dout[i] = 1'b0;
                oe[i]   = ~dir[i] & ~ana[i] & ~lat[i];
            end else begin
                dout[i] = lat[i];
                oe[i]   = ~dir[i] & ~ana[i];
            end
        end
        od = odr;
        pu = pup;
        pd = pdn & ~pup;
    end
endmodule

// File: rtl/gpio_port16.sv
// Register-mapped control for one 16-pin GPIO port with clear/set/invert aliases.
// Assumes a single-cycle strobe bus; reads return data one cycle after bus_rd.
module gpio_port16
    import gpio_port16_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [BUS_W-1:0]     bus_wdata,
    input  logic                 bus_rd,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [PINS-1:0]      pad_in,
    output logic [PINS-1:0]      pad_oe,
    output logic [PINS-1:0]      pad_out,
    output logic [PINS-1:0]      pad_od,
    output logic [PINS-1:0]      pad_pu,
    output logic [PINS-1:0]      pad_pd,
    output logic [PINS-1:0]      pad_analog
);
    localparam logic [PINS-1:0] ONES = '1;

    logic [SLOT_W-1:0]  slot;
    alias_e             op;
    logic [PINS-1:0]    regs [NUM_CTRL];
    logic [PINS-1:0]    pin_sync;
    logic [PINS-1:0]    rd_val;

    assign slot = bus_addr[7:4];
    assign op   = alias_e'(bus_addr[3:2]);

    // One storage register per control slot; slot 2 has none (aliases latch)
    for (genvar s = 0; s < NUM_CTRL; s++) begin : g_reg
        if (s == int'(SLOT_PIN)) begin : g_none
            assign regs[s] = '0;
        end else begin : g_store
            localparam logic [PINS-1:0] RV =
                (s == int'(SLOT_ANA) || s == int'(SLOT_DIR)) ? ONES : '0;
            logic hit;
            // Latch slot also accepts writes aimed at the input slot
            assign hit = bus_wr && ((slot == SLOT_W'(s)) ||
                         (s == int'(SLOT_LAT) && slot == SLOT_PIN));
            gpio_bit_reg #(.W(PINS), .RST_VAL(RV)) u_reg (
                .clk  (clk),
                .rst_n(rst_n),
                .upd  (hit),
                .op   (op),
                .data (bus_wdata[PINS-1:0]),
                .q    (regs[s])
            );
        end
    end

    gpio_in_sync #(.W(PINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (pin_sync)
    );

    gpio_pad_ctrl #(.W(PINS)) u_pad (
        .ana (regs[SLOT_ANA]),
        .dir (regs[SLOT_DIR]),
        .lat (regs[SLOT_LAT]),
        .odr (regs[SLOT_ODR]),
        .pup (regs[SLOT_PUP]),
        .pdn (regs[SLOT_PDN]),
        .oe  (pad_oe),
        .dout(pad_out),
        .od  (pad_od),
        .pu  (pad_pu),
        .pd  (pad_pd)
    );

    assign pad_analog = regs[SLOT_ANA];

    // Select the read value by slot
    always_comb begin
        if (slot == SLOT_PIN)               rd_val = pin_sync & ~regs[SLOT_ANA];
        else if (slot < SLOT_W'(NUM_CTRL))  rd_val = regs[slot[2:0]];
        else                                rd_val = '0;
    end

    // Register read data on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= {{(BUS_W-PINS){1'b0}}, rd_val};
    end
endmodule

// File: rtl/gpio_port16_chk.sv
// Assertion checker bound to gpio_port16; observes ports only.
module gpio_port16_chk
    import gpio_port16_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              bus_rd,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [PINS-1:0]   pad_oe,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_od,
    input logic [PINS-1:0]   pad_pu,
    input logic [PINS-1:0]   pad_pd,
    input logic [PINS-1:0]   pad_analog
);
    // R1
    rst_analog_chk: assert property (@(posedge clk)
        !rst_n |=> (pad_analog == '1 && pad_oe == '0 && pad_pu == '0));

    // R4
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1:PINS] == '0);

    // R9
    pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0);

    // R8
    od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_od & pad_out) == '0);

    // R7
    ana_noe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_analog & pad_oe) == '0);

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && rst_n && $past(rst_n)) |=> $stable(bus_rdata));

    // R3
    set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[7:2] == 6'b000010) |=>
        ((pad_analog & $past(bus_wdata[PINS-1:0])) == $past(bus_wdata[PINS-1:0])));
endmodule

bind gpio_port16 gpio_port16_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_od(pad_od), .pad_pu(pad_pu),
    .pad_pd(pad_pd), .pad_analog(pad_analog)
);

// File: tb/gpio_port16_tb_top.sv
module gpio_port16_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_oe, pad_out, pad_od, pad_pu, pad_pd, pad_analog;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port16 dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_od(pad_od),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_analog(pad_analog)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at negedge; write takes effect at the next posedge
    task automatic wr(input int slot, input int op, input logic [15:0] d);
        @(negedge clk);
        bus_addr = 8'((slot << 4) | (op << 2));
        bus_wdata = {16'hDEAD, d};
        bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input int slot, input int op, output logic [31:0] v);
        @(negedge clk);
        bus_addr = 8'((slot << 4) | (op << 2));
        bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
        v = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, 0, v); check("R1 ana", v, 32'h0000FFFF);
        rd(1, 0, v); check("R1 dir", v, 32'h0000FFFF);
        rd(3, 0, v); check("R1 lat", v, 32'h0);
        rd(7, 0, v); check("R1 chg", v, 32'h0);
        check("R1 oe", {16'h0, pad_oe}, 32'h0);
    endtask

    task automatic t_alias();
        logic [31:0] v;
        wr(4, 0, 16'h00F0);
        rd(4, 0, v); check("R3 load", v, 32'h000000F0);
        wr(4, 2, 16'h0101);
        rd(4, 3, v); check("R3 set / R4 alias read", v, 32'h000001F1);
        wr(4, 1, 16'h0030);
        rd(4, 1, v); check("R3 clr", v, 32'h000001C1);
        wr(4, 3, 16'h8041);
        rd(4, 2, v); check("R3 inv", v, 32'h00008180);
        rd(9, 0, v); check("R4 unused slot", v, 32'h0);
        wr(9, 0, 16'hFFFF);
        rd(4, 0, v); check("R4 unused write", v, 32'h00008180);
        check("R2 od pad", {16'h0, pad_od}, 32'h00008180);
    endtask

    task automatic t_latch_alias();
        logic [31:0] v;
        wr(2, 0, 16'h1234);
        rd(3, 0, v); check("R5 pin->lat load", v, 32'h00001234);
        wr(2, 2, 16'h0008);
        rd(3, 0, v); check("R5 pin->lat set", v, 32'h0000123C);
    endtask

    task automatic t_input();
        logic [31:0] v;
        wr(0, 0, 16'hFF00);
        @(negedge clk); pad_in = 16'hA5A5;
        @(negedge clk);
        check("R6 one edge", {16'h0, dut_i.pad_in}, 32'h0000A5A5);
        @(negedge clk);
        rd(2, 0, v); check("R6 sync+analog mask", v, 32'h000000A5);
    endtask

    task automatic t_pads();
        wr(0, 0, 16'h0000);
        wr(1, 0, 16'hFF00);
        wr(4, 0, 16'h000F);
        wr(3, 0, 16'h0055);
        @(negedge clk);
        check("R7 oe", {16'h0, pad_oe}, 32'h000000FA);
        check("R8 out", {16'h0, pad_out}, 32'h00000050);
        wr(5, 0, 16'h00F0);
        wr(6, 0, 16'h0F30);
        @(negedge clk);
        check("R9 pu", {16'h0, pad_pu}, 32'h000000F0);
        check("R9 pd", {16'h0, pad_pd}, 32'h00000F00);
    endtask

    task automatic t_rd_timing();
        @(negedge clk);
        bus_addr = 8'h10; bus_rd = 1;
        @(negedge clk); bus_rd = 0;
        check("R10 rd latency", bus_rdata, 32'h0000FF00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_alias();
        t_latch_alias();
        t_input();
        t_pads();
        t_rd_timing();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule